// File: doc/BRIEF.md
# Horizontal Register Pixel Clock Generator

This block produces the horizontal readout clocks for an image sensor with four output registers. For every register it drives a phase-1 clock, a phase-2 clock, a separately driven last-phase clock and a reset-gate pulse. It also produces one converter sample strobe per pixel. Each phase output feeds both the storage gate and the barrier gate of that phase. A pixel's charge reaches the output node when the last-phase clock falls.

The vertical sequencer starts a line with a one-cycle start pulse. The block then captures the readout mode and the timing settings, and clocks out the requested number of pixels. The count is raised to a floor that depends on the readout mode. When the last pixel has been sampled, the block pulses line done. Each pixel period lasts a programmable number of system-clock ticks. The tick on which the reset gate pulses, the tick on which the last phase falls and the tick on which the sample strobe fires are all programmable. Registers that the chosen mode does not use are parked with every gate held high. Between lines, the registers in use rest in a fixed idle pattern.

Top module: `hclk_gen`

## Requirements
- R1: After reset, every register shows phase-1 low, phase-2 high, last-phase high and reset gate low, and strobe, busy and line done are low. The registers in use return to this idle pattern whenever no line is running.
- R2: The pixel period is P = max(period_m1_i, 1) + 1 ticks, and H = P/2 rounded down. Tick 0 is the first cycle after start is accepted. During ticks 0..H-1 phase-2 is high and phase-1 is low; during ticks H..P-1 the two are swapped.
- R3: The last-phase clock is high from tick 0 and falls at tick min(slf_tick_i, H). It never stays high beyond the phase-2 high interval.
- R4: The reset gate is high only on tick rst_tick_i of each pixel, and the sample strobe only on tick smp_tick_i. Each fires once per pixel.
- R5: A line has N = max(npix_i, floor) pixels. The floor is MIN_SINGLE in mode 0 and MIN_MULTI in modes 1 to 3. Line done is high for exactly one cycle, the cycle after the strobe of pixel N-1.
- R6: mode_i selects the registers in use: 0 selects register 0 only, 1 selects registers 0 and 1, 2 selects registers 0 and 2, and 3 selects all four. A register that is not selected holds phase-1, phase-2, last-phase and reset gate all high.
- R7: Mode, pixel count and tick settings are captured in the cycle start is accepted. A start pulse or a change to these inputs while a line runs has no effect on that line.
- R8: busy_o is high from the cycle after an accepted start through the last tick of pixel N-1, and low afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Line start pulse from vertical sequencer |
| mode_i | input | 2 | Readout mode (register selection) |
| npix_i | input | PIX_W | Requested pixels per line |
| period_m1_i | input | TICK_W | Pixel period in ticks minus one |
| rst_tick_i | input | TICK_W | Tick of the reset-gate pulse |
| slf_tick_i | input | TICK_W | Tick of the last-phase fall |
| smp_tick_i | input | TICK_W | Tick of the sample strobe |
| busy_o | output | 1 | Line in progress |
| h1_o | output | 4 | Phase-1 clock per register |
| h2_o | output | 4 | Phase-2 clock per register |
| hsl_o | output | 4 | Last-phase clock per register |
| rg_o | output | 4 | Reset-gate pulse per register |
| strobe_o | output | 1 | Sample strobe |
| line_done_o | output | 1 | One-cycle line done pulse |

## Verification
The properties assume that the reset-tick and sample-tick settings lie below the pixel period, so each pulse fires once per pixel. They also assume that the mode floors are at least one. The stimulus table keeps every tick setting inside the period, and it includes a period setting of zero to exercise the two-tick clamp. One line is disturbed by a second start pulse and by changed settings, and this must leave its waveform and length exactly as captured.

// File: rtl/hclk_pkg.sv
package hclk_pkg;
    localparam int NREG = 4;

    typedef enum logic [1:0] {
        RD_SINGLE  = 2'd0,
        RD_DUAL_LR = 2'd1,
        RD_DUAL_TB = 2'd2,
        RD_QUAD    = 2'd3
    } rd_mode_e;

    function automatic logic [NREG-1:0] mode_mask(input rd_mode_e m);
        case (m)
            RD_SINGLE:  mode_mask = 4'b0001;
            RD_DUAL_LR: mode_mask = 4'b0011;
            RD_DUAL_TB: mode_mask = 4'b0101;
            default:    mode_mask = 4'b1111;
        endcase
    endfunction
endpackage

// File: rtl/hclk_seq.sv
module hclk_seq import hclk_pkg::*; #(
    parameter int TICK_W     = 4,
    parameter int PIX_W      = 14,
    parameter int MIN_SINGLE = 10572,
    parameter int MIN_MULTI  = 5292
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        mode_i,
    input  logic [PIX_W-1:0]  npix_i,
    input  logic [TICK_W-1:0] period_m1_i,
    input  logic [TICK_W-1:0] rst_tick_i,
    input  logic [TICK_W-1:0] slf_tick_i,
    input  logic [TICK_W-1:0] smp_tick_i,
    output logic              busy_o,
    output logic [TICK_W-1:0] tick_o,
    output logic [TICK_W-1:0] half_o,
    output logic [TICK_W-1:0] slf_o,
    output logic [TICK_W-1:0] rst_tick_o,
    output logic [TICK_W-1:0] smp_tick_o,
    output logic [NREG-1:0]   mask_o,
    output logic              done_o
);
    localparam logic [PIX_W-1:0] FLOOR_S = PIX_W'(MIN_SINGLE);
    localparam logic [PIX_W-1:0] FLOOR_M = PIX_W'(MIN_MULTI);

    typedef struct packed {
        logic              busy;
        logic [TICK_W-1:0] tick;
        logic [PIX_W-1:0]  pix;
        logic [PIX_W-1:0]  npix;
        logic [TICK_W-1:0] pm1;
        logic [TICK_W-1:0] half;
        logic [TICK_W-1:0] slf;
        logic [TICK_W-1:0] rst_t;
        logic [TICK_W-1:0] smp_t;
        logic [NREG-1:0]   mask;
        logic              done;
    } seq_t;

    seq_t q, d;
    logic [PIX_W-1:0]  floor_v, npix_eff;
    logic [TICK_W-1:0] pm1_eff, half_v;
    logic [TICK_W:0]   period_v;
    logic              last_pix;

    always_comb begin
        floor_v  = (rd_mode_e'(mode_i) == RD_SINGLE) ? FLOOR_S : FLOOR_M;
        npix_eff = (npix_i < floor_v) ? floor_v : npix_i;
        pm1_eff  = (period_m1_i == '0) ? TICK_W'(1) : period_m1_i;
        period_v = {1'b0, pm1_eff} + 1'b1;
        half_v   = period_v[TICK_W:1];
        last_pix = (q.pix == q.npix - 1'b1);

        d      = q;
        d.done = 1'b0;
        if (!q.busy) begin
            if (start_i) begin
                d.busy  = 1'b1;
                d.tick  = '0;
                d.pix   = '0;
                d.npix  = npix_eff;
                d.pm1   = pm1_eff;
                d.half  = half_v;
                d.slf   = (slf_tick_i < half_v) ? slf_tick_i : half_v;
                d.rst_t = rst_tick_i;
                d.smp_t = smp_tick_i;
                d.mask  = mode_mask(rd_mode_e'(mode_i));
            end
        end else begin
            if (last_pix && q.tick == q.smp_t) d.done = 1'b1;
            if (q.tick == q.pm1) begin
                d.tick = '0;
                if (last_pix) d.busy = 1'b0;
                else          d.pix  = q.pix + 1'b1;
            end else begin
                d.tick = q.tick + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.pm1  <= TICK_W'(1);
            q.half <= TICK_W'(1);
            q.mask <= '1;
        end else begin
            q <= d;
        end
    end

    assign busy_o     = q.busy;
    assign tick_o     = q.tick;
    assign half_o     = q.half;
    assign slf_o      = q.slf;
    assign rst_tick_o = q.rst_t;
    assign smp_tick_o = q.smp_t;
    assign mask_o     = q.mask;
    assign done_o     = q.done;

    // R2: the tick counter stays inside the captured period
    p_tick_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        q.tick <= q.pm1);

    // R7: captured settings hold for the whole line
    p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && $past(q.busy)) |-> ($stable(q.npix) && $stable(q.mask) && $stable(q.pm1)));
endmodule

// File: rtl/hclk_lane.sv
module hclk_lane #(
    parameter int TICK_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active_i,
    input  logic              busy_i,
    input  logic [TICK_W-1:0] tick_i,
    input  logic [TICK_W-1:0] half_i,
    input  logic [TICK_W-1:0] slf_i,
    input  logic [TICK_W-1:0] rst_tick_i,
    output logic              h1_o,
    output logic              h2_o,
    output logic              hsl_o,
    output logic              rg_o
);
    always_comb begin
        if (!active_i) begin
            h1_o = 1'b1; h2_o = 1'b1; hsl_o = 1'b1; rg_o = 1'b1;
        end else if (!busy_i) begin
            h1_o = 1'b0; h2_o = 1'b1; hsl_o = 1'b1; rg_o = 1'b0;
        end else begin
            h2_o  = (tick_i < half_i);
            h1_o  = ~h2_o;
            hsl_o = (tick_i < slf_i);
            rg_o  = (tick_i == rst_tick_i);
        end
    end

    // R3: the last phase is never high while phase 2 is low in an active line
    p_hsl_in_h2_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && busy_i && hsl_o) |-> h2_o);
endmodule

// File: rtl/hclk_gen.sv
module hclk_gen import hclk_pkg::*; #(
    parameter int TICK_W     = 4,
    parameter int PIX_W      = 14,
    parameter int MIN_SINGLE = 10572,
    parameter int MIN_MULTI  = 5292
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        mode_i,
    input  logic [PIX_W-1:0]  npix_i,
    input  logic [TICK_W-1:0] period_m1_i,
    input  logic [TICK_W-1:0] rst_tick_i,
    input  logic [TICK_W-1:0] slf_tick_i,
    input  logic [TICK_W-1:0] smp_tick_i,
    output logic              busy_o,
    output logic [NREG-1:0]   h1_o,
    output logic [NREG-1:0]   h2_o,
    output logic [NREG-1:0]   hsl_o,
    output logic [NREG-1:0]   rg_o,
    output logic              strobe_o,
    output logic              line_done_o
);
    logic              busy_w;
    logic [TICK_W-1:0] tick_w, half_w, slf_w, rstt_w, smpt_w;
    logic [NREG-1:0]   mask_w;

    hclk_seq #(
        .TICK_W(TICK_W), .PIX_W(PIX_W),
        .MIN_SINGLE(MIN_SINGLE), .MIN_MULTI(MIN_MULTI)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .npix_i(npix_i), .period_m1_i(period_m1_i), .rst_tick_i(rst_tick_i),
        .slf_tick_i(slf_tick_i), .smp_tick_i(smp_tick_i),
        .busy_o(busy_w), .tick_o(tick_w), .half_o(half_w), .slf_o(slf_w),
        .rst_tick_o(rstt_w), .smp_tick_o(smpt_w), .mask_o(mask_w),
        .done_o(line_done_o)
    );

    for (genvar r = 0; r < NREG; r++) begin : g_lane
        hclk_lane #(.TICK_W(TICK_W)) u_lane (
            .clk(clk), .rst_n(rst_n), .active_i(mask_w[r]), .busy_i(busy_w),
            .tick_i(tick_w), .half_i(half_w), .slf_i(slf_w), .rst_tick_i(rstt_w),
            .h1_o(h1_o[r]), .h2_o(h2_o[r]), .hsl_o(hsl_o[r]), .rg_o(rg_o[r])
        );
    end

    assign busy_o   = busy_w;
    assign strobe_o = busy_w && (tick_w == smpt_w);

    // R5: line done only right after a sample strobe
    p_done_after_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        line_done_o |-> $past(strobe_o));

    // R4: a strobe never lasts two cycles (period is at least two ticks)
    p_single_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |=> !strobe_o);

    // R1: outside a line there is no strobe and no reset pulse on used registers
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!strobe_o && ((rg_o & mask_w) == '0)));
endmodule

// File: tb/tb_hclk_gen.sv
module tb_hclk_gen;
    localparam int TICK_W = 4;
    localparam int PIX_W  = 14;
    localparam int MIN_S  = 12;
    localparam int MIN_M  = 6;
    localparam int NV     = 5;

    localparam int V_MODE[NV] = '{3, 0, 1, 2, 1};
    localparam int V_NPIX[NV] = '{8, 3, 6, 10, 0};
    localparam int V_PM1 [NV] = '{3, 5, 4, 1, 0};
    localparam int V_RST [NV] = '{0, 1, 4, 1, 0};
    localparam int V_SLF [NV] = '{1, 5, 2, 1, 0};
    localparam int V_SMP [NV] = '{3, 2, 0, 1, 0};

    logic clk = 0, rst_n = 0, start = 0;
    logic [1:0] mode = 0;
    logic [PIX_W-1:0] npix = 0;
    logic [TICK_W-1:0] pm1 = 0, rstt = 0, slft = 0, smpt = 0;
    logic busy, strobe, done;
    logic [3:0] h1, h2, hsl, rg;
    int total = 0, bad = 0;

    always #4 clk = ~clk;

    hclk_gen #(.TICK_W(TICK_W), .PIX_W(PIX_W), .MIN_SINGLE(MIN_S), .MIN_MULTI(MIN_M)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .mode_i(mode), .npix_i(npix),
        .period_m1_i(pm1), .rst_tick_i(rstt), .slf_tick_i(slft), .smp_tick_i(smpt),
        .busy_o(busy), .h1_o(h1), .h2_o(h2), .hsl_o(hsl), .rg_o(rg),
        .strobe_o(strobe), .line_done_o(done)
    );

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", what, act, exp);
        end
    endtask

    function automatic int lanes();
        return {h1, h2, hsl, rg};
    endfunction

    function automatic logic [3:0] mask_of(input int m);
        case (m)
            0: return 4'b0001;
            1: return 4'b0011;
            2: return 4'b0101;
            default: return 4'b1111;
        endcase
    endfunction

    task automatic run_line(input int i, input bit disturb);
        int m = V_MODE[i];
        int p = ((V_PM1[i] < 1) ? 1 : V_PM1[i]) + 1;
        int hf = p / 2;
        int sl = (V_SLF[i] < hf) ? V_SLF[i] : hf;
        int fl = (m == 0) ? MIN_S : MIN_M;
        int n = (V_NPIX[i] < fl) ? fl : V_NPIX[i];
        int tot = n * p;
        int done_c = (n - 1) * p + V_SMP[i] + 1;
        logic [3:0] mk = mask_of(m);
        @(negedge clk);
        mode = 2'(m); npix = PIX_W'(V_NPIX[i]); pm1 = TICK_W'(V_PM1[i]);
        rstt = TICK_W'(V_RST[i]); slft = TICK_W'(V_SLF[i]); smpt = TICK_W'(V_SMP[i]);
        start = 1;
        @(negedge clk);
        start = 0;
        for (int c = 0; c < tot + 3; c++) begin
            bit b = (c < tot);
            int t = c % p;
            logic [3:0] e1, e2, es, er;
            for (int r = 0; r < 4; r++) begin
                if (!mk[r])  begin e1[r] = 1; e2[r] = 1; es[r] = 1; er[r] = 1; end
                else if (!b) begin e1[r] = 0; e2[r] = 1; es[r] = 1; er[r] = 0; end
                else begin
                    e2[r] = (t < hf); e1[r] = !(t < hf);
                    es[r] = (t < sl); er[r] = (t == V_RST[i]);
                end
            end
            chk(lanes() == int'({e1, e2, es, er}), "R1 R2 R3 R4 R6 register clocks",
                lanes(), int'({e1, e2, es, er}));
            chk(strobe == (b && t == V_SMP[i]), "R4 strobe", strobe, b && t == V_SMP[i]);
            chk(busy == b, "R8 busy", busy, b);
            chk(done == (c == done_c), "R5 line done", done, c == done_c);
            if (disturb && c == 2) begin
                start = 1; mode = 2'd3; npix = 1; pm1 = 4'd1; smpt = 0; rstt = 0;
            end else if (disturb && c == 3) begin
                start = 0; mode = 2'(m); npix = PIX_W'(V_NPIX[i]); pm1 = TICK_W'(V_PM1[i]);
                smpt = TICK_W'(V_SMP[i]); rstt = TICK_W'(V_RST[i]);
            end
            @(negedge clk);
        end
    endtask

    initial begin
        fork
            begin
                #1 rst_n = 0;
                repeat (3) @(negedge clk);
                // R1: reset state
                chk(lanes() == 16'h0FF0, "R1 reset clocks", lanes(), 16'h0FF0);
                chk({strobe, busy, done} == 3'b000, "R1 reset status", {strobe, busy, done}, 0);
                rst_n = 1;
                @(negedge clk);
                chk(lanes() == 16'h0FF0, "R1 idle after reset", lanes(), 16'h0FF0);
                // table walk; line 2 is disturbed mid-line (R7)
                for (int i = 0; i < NV; i++) run_line(i, i == 2);
                // R7 explicit: another run of the disturbed vector, then idle (R1)
                run_line(2, 1'b1);
                chk(busy == 0, "R7 no extra line after ignored start", busy, 0);
            end
            begin
                repeat (20000) @(posedge clk);
                chk(0, "watchdog expired", 0, 1);
            end
        join_any
        disable fork;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule